// File: doc/BRIEF.md
# Receive Buffer Pause Request Generator

This block watches the byte fill level of several receive packet buffers and asks the MAC transmit path for a pause (XOFF) frame when one of them becomes congested. Each buffer has a 32-bit configuration word that holds an enable bit and a high water mark with 16-byte granularity. Each buffer also has a separate low water mark. The request leaves the block on a valid/ready pair together with the index of the buffer that caused it.

A crossing of the high mark is detected as an edge. After a buffer has caused a request, it cannot cause another one until it first drains below its low mark. While any enabled buffer stays at or above its low mark, a shared refresh counter re-issues the request at a programmable interval, measured in cycles of a tick enable. A paused flag shows that a pause frame has been accepted and that congestion has not yet cleared.

Back-pressure: `xoff_valid` stays high and `xoff_idx` stays stable until a cycle in which `xoff_ready` is high. A transfer takes place in that cycle, and a further queued request may present itself in the very next cycle. Requests that cannot be presented wait internally, with no limit on how long.

Top module: `xoff_req_gen`

## Requirements
- R1: Buffer k is over its high mark when its enable is set and `fill_level[k]` >= (bits 18:4 of `hi_cfg[k]`) × 16. Bits 30:19 and 3:0 of the word have no effect. When an armed buffer goes over its high mark, `xoff_valid` is high after the next clock edge with `xoff_idx` = k.
- R2: A buffer whose enable bit (bit 31 of its `hi_cfg` word) is clear never causes a request, whatever its fill level.
- R3: While `fc_tx_en` is low, no new request is presented and queued requests are dropped. A buffer still over its mark requests once `fc_tx_en` rises.
- R4: A buffer that has caused a request causes no further edge request until its fill drops below `lo_thr[k]` × 16 and then crosses the high mark again.
- R5: When several requests wait at once, the lowest buffer index is presented first. The others follow, one per transfer, with no idle cycle between them.
- R6: While `xoff_valid` is high and `xoff_ready` is low, `xoff_valid` stays high and `xoff_idx` does not change.
- R7: `paused` rises on the edge after a transfer. It falls on the first edge, with no transfer, at which every enabled buffer is below its low mark. Disabled buffers never hold it high.
- R8: After a transfer, while still paused, a refresh request is presented after the edge on which `refresh_thr` ticks have elapsed. Its index is the lowest enabled buffer at or above its low mark. A `refresh_thr` of zero disables refresh.
- R9: The refresh count advances only on cycles with `tick_en` high, so a low `tick_en` delays the refresh without limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fc_tx_en | input | 1 | Global enable for sending flow-control frames |
| tick_en | input | 1 | Refresh counter advance strobe |
| fill_level | input | NUM_BUF×FILL_W | Byte fill level of each buffer |
| hi_cfg | input | NUM_BUF×32 | Per-buffer word: bit 31 enable, bits 18:4 high mark in 16-byte units |
| lo_thr | input | NUM_BUF×15 | Per-buffer low mark in 16-byte units |
| refresh_thr | input | REFRESH_W | Refresh interval in ticks, 0 = off |
| xoff_valid | output | 1 | Pause frame request |
| xoff_ready | input | 1 | Transmitter accepts the request |
| xoff_idx | output | IDX_W | Buffer that caused the request |
| paused | output | 1 | Pause state is held |

## Verification
The bench builds the block with four buffers, a 10-bit fill level and a 4-bit refresh threshold. With these values, the fill level can be swept across every high mark from 16 to 96 bytes on every buffer, with the reserved configuration bits set to ones. Every nonzero refresh interval, 1 through 15, is also measured cycle by cycle. Four buffers are enough to show priority among three simultaneous requests and a refresh index chosen below the one that caused the pause.

// File: rtl/xoff_pkg.sv
package xoff_pkg;
  localparam int CFG_W      = 32;
  localparam int CFG_EN_BIT = 31;
  localparam int THR_LSB    = 4;
  localparam int THR_W      = 15;
  localparam int GRAN_SH    = 4;   // 16-byte granularity

  // index of lowest set bit, 0 when none
  function automatic logic [4:0] lowest_set(input logic [31:0] v);
    logic [4:0] r;
    r = '0;
    for (int k = 31; k >= 0; k--) begin
      if (v[k]) r = 5'(k);
    end
    return r;
  endfunction
endpackage

// File: rtl/xoff_buf_mon.sv
module xoff_buf_mon
  import xoff_pkg::*;
#(
  parameter int FILL_W = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fc_en,
  input  logic [FILL_W-1:0]      fill,
  input  logic [CFG_W-1:0]       cfg,
  input  logic [THR_W-1:0]       lo_units,
  output logic                   trig,
  output logic                   cong
);
  localparam int CMP_W = (FILL_W > THR_W + GRAN_SH) ? FILL_W : THR_W + GRAN_SH;

  logic [CMP_W-1:0] fill_b, hi_b, lo_b;
  logic             en, over_hi, under_lo, armed;
  logic             cfg_unused;

  assign cfg_unused = ^{cfg[30:THR_LSB+THR_W], cfg[THR_LSB-1:0]};
  assign en       = cfg[CFG_EN_BIT];
  assign fill_b   = CMP_W'(fill);
  assign hi_b     = CMP_W'({cfg[THR_LSB +: THR_W], {GRAN_SH{1'b0}}});
  assign lo_b     = CMP_W'({lo_units, {GRAN_SH{1'b0}}});
  assign over_hi  = en && (fill_b >= hi_b);
  assign under_lo = fill_b < lo_b;
  assign trig     = over_hi && armed && fc_en;
  assign cong     = en && !under_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed <= 1'b1;
    else if (under_lo) armed <= 1'b1;
    else if (trig)     armed <= 1'b0;
  end
endmodule

// File: rtl/xoff_refresh.sv
module xoff_refresh #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             paused,
  input  logic             xfer,
  input  logic             tick,
  input  logic             congested,
  input  logic [CNT_W-1:0] thr,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;
  logic             live;

  assign live   = paused && tick && (thr != '0);
  assign expire = live && !xfer && congested && (cnt == thr - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (xfer || !paused)    cnt <= '0;
    else if (live && cnt != thr) cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/xoff_arb.sv
module xoff_arb
  import xoff_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fc_en,
  input  logic [N-1:0]     set_vec,
  input  logic             ready,
  output logic             valid,
  output logic [IDX_W-1:0] idx
);
  logic [N-1:0]     pending, req_vec, grant_oh;
  logic [IDX_W-1:0] sel;
  logic             load;

  assign req_vec  = pending | set_vec;
  assign sel      = IDX_W'(lowest_set(32'(req_vec)));
  assign grant_oh = N'(1) << sel;
  assign load     = fc_en && (!valid || ready) && (req_vec != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
      valid   <= 1'b0;
      idx     <= '0;
    end else begin
      if (!fc_en)    pending <= '0;
      else if (load) pending <= req_vec & ~grant_oh;
      else           pending <= req_vec;
      if (load) begin
        valid <= 1'b1;
        idx   <= sel;
      end else if (ready) begin
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/xoff_req_gen.sv
module xoff_req_gen
  import xoff_pkg::*;
#(
  parameter int NUM_BUF   = 8,
  parameter int FILL_W    = 20,
  parameter int REFRESH_W = 16,
  localparam int IDX_W    = $clog2(NUM_BUF)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                fc_tx_en,
  input  logic                                tick_en,
  input  logic [NUM_BUF-1:0][FILL_W-1:0]      fill_level,
  input  logic [NUM_BUF-1:0][CFG_W-1:0]       hi_cfg,
  input  logic [NUM_BUF-1:0][THR_W-1:0]       lo_thr,
  input  logic [REFRESH_W-1:0]                refresh_thr,
  output logic                                xoff_valid,
  input  logic                                xoff_ready,
  output logic [IDX_W-1:0]                    xoff_idx,
  output logic                                paused
);
  logic [NUM_BUF-1:0] trig_vec, cong_vec, refresh_oh, set_vec;
  logic               any_cong, xfer, expire;

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_mon
    xoff_buf_mon #(.FILL_W(FILL_W)) u_mon (
      .clk      (clk),
      .rst_n    (rst_n),
      .fc_en    (fc_tx_en),
      .fill     (fill_level[g]),
      .cfg      (hi_cfg[g]),
      .lo_units (lo_thr[g]),
      .trig     (trig_vec[g]),
      .cong     (cong_vec[g])
    );
  end

  assign any_cong   = |cong_vec;
  assign xfer       = xoff_valid && xoff_ready;
  assign refresh_oh = NUM_BUF'(1) << IDX_W'(lowest_set(32'(cong_vec)));
  assign set_vec    = trig_vec | ((expire && fc_tx_en) ? refresh_oh : '0);

  xoff_refresh #(.CNT_W(REFRESH_W)) u_refresh (
    .clk       (clk),
    .rst_n     (rst_n),
    .paused    (paused),
    .xfer      (xfer),
    .tick      (tick_en),
    .congested (any_cong),
    .thr       (refresh_thr),
    .expire    (expire)
  );

  xoff_arb #(.N(NUM_BUF), .IDX_W(IDX_W)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .fc_en   (fc_tx_en),
    .set_vec (set_vec),
    .ready   (xoff_ready),
    .valid   (xoff_valid),
    .idx     (xoff_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         paused <= 1'b0;
    else if (xfer)      paused <= 1'b1;
    else if (!any_cong) paused <= 1'b0;
  end
endmodule

// File: rtl/xoff_req_gen_chk.sv
module xoff_req_gen_chk
  import xoff_pkg::*;
#(
  parameter int NUM_BUF   = 8,
  parameter int FILL_W    = 20,
  parameter int IDX_W     = 3
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           fc_tx_en,
  input logic [NUM_BUF-1:0][FILL_W-1:0] fill_level,
  input logic [NUM_BUF-1:0][CFG_W-1:0]  hi_cfg,
  input logic [NUM_BUF-1:0][THR_W-1:0]  lo_thr,
  input logic                           xoff_valid,
  input logic                           xoff_ready,
  input logic [IDX_W-1:0]               xoff_idx,
  input logic                           paused
);
  localparam int CMP_W = (FILL_W > THR_W + GRAN_SH) ? FILL_W : THR_W + GRAN_SH;

  logic               all_low;
  logic [NUM_BUF-1:0] en_q;

  always_comb begin
    all_low = 1'b1;
    for (int k = 0; k < NUM_BUF; k++) begin
      if (hi_cfg[k][CFG_EN_BIT] &&
          (CMP_W'(fill_level[k]) >= CMP_W'({lo_thr[k], {GRAN_SH{1'b0}}})))
        all_low = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else for (int k = 0; k < NUM_BUF; k++) en_q[k] <= hi_cfg[k][CFG_EN_BIT];
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xoff_valid && !xoff_ready |=> xoff_valid && $stable(xoff_idx));

  assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_tx_en && !xoff_valid |=> !xoff_valid);

  assert_idx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xoff_valid |-> (32'(xoff_idx) < NUM_BUF));

  assert_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xoff_valid) |-> en_q[xoff_idx]);

  assert_pause_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xoff_valid && xoff_ready |=> paused);

  assert_pause_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    paused && !(xoff_valid && xoff_ready) && all_low |=> !paused);
endmodule

bind xoff_req_gen xoff_req_gen_chk #(
  .NUM_BUF (NUM_BUF),
  .FILL_W  (FILL_W),
  .IDX_W   (IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fc_tx_en   (fc_tx_en),
  .fill_level (fill_level),
  .hi_cfg     (hi_cfg),
  .lo_thr     (lo_thr),
  .xoff_valid (xoff_valid),
  .xoff_ready (xoff_ready),
  .xoff_idx   (xoff_idx),
  .paused     (paused)
);

// File: tb/xoff_req_gen_bench.sv
`timescale 1ns/1ps
module xoff_req_gen_bench;
  localparam int NB = 4;
  localparam int FW = 10;
  localparam int RW = 4;
  localparam int IW = 2;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   fc_tx_en = 1'b1;
  logic                   tick_en = 1'b1;
  logic [NB-1:0][FW-1:0]  fill_level = '0;
  logic [NB-1:0][31:0]    hi_cfg = '0;
  logic [NB-1:0][14:0]    lo_thr = '0;
  logic [RW-1:0]          refresh_thr = '0;
  logic                   xoff_valid, xoff_ready = 1'b0, paused;
  logic [IW-1:0]          xoff_idx;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xoff_req_gen #(.NUM_BUF(NB), .FILL_W(FW), .REFRESH_W(RW)) u_xoff_req_gen (
    .clk(clk), .rst_n(rst_n), .fc_tx_en(fc_tx_en), .tick_en(tick_en),
    .fill_level(fill_level), .hi_cfg(hi_cfg), .lo_thr(lo_thr),
    .refresh_thr(refresh_thr), .xoff_valid(xoff_valid),
    .xoff_ready(xoff_ready), .xoff_idx(xoff_idx), .paused(paused)
  );

  // reserved bits deliberately set to ones
  function automatic logic [31:0] mk_cfg(input bit en, input int units);
    return {en, 12'hFFF, 15'(units), 4'hF};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic xfer();
    xoff_ready = 1'b1; step(); xoff_ready = 1'b0;
  endtask

  task automatic clear_all();
    fill_level = '0; xoff_ready = 1'b0;
    step(); step();
    while (xoff_valid) xfer();
    step();
  endtask

  // cycles after a transfer until a refresh request appears
  task automatic wait_req(output int n);
    n = 0;
    while (!xoff_valid && n < 60) begin step(); n++; end
  endtask

  initial begin
    int n;
    bit exp;
    repeat (3) @(negedge clk);
    chk("reset valid", int'(xoff_valid), 0);
    chk("reset paused", int'(paused), 0);
    rst_n = 1'b1;
    step();
    for (int k = 0; k < NB; k++) lo_thr[k] = 15'd1;

    // R1: sweep fill across each high mark on every buffer
    for (int i = 0; i < NB; i++) begin
      for (int h = 1; h <= 6; h++) begin
        for (int f = h*16 - 2; f <= h*16 + 1; f++) begin
          clear_all();
          hi_cfg = '0;
          hi_cfg[i] = mk_cfg(1'b1, h);
          fill_level[i] = FW'(f);
          step();
          exp = (f >= h*16);
          chk("R1 threshold compare", int'(xoff_valid), int'(exp));
          if (exp) chk("R1 index", int'(xoff_idx), i);
        end
      end
    end

    // R2: disabled buffer ignored
    clear_all();
    hi_cfg = '0;
    hi_cfg[2] = mk_cfg(1'b0, 4);
    fill_level[2] = FW'(1000);
    repeat (4) step();
    chk("R2 disabled no request", int'(xoff_valid), 0);
    hi_cfg[2] = mk_cfg(1'b1, 4);
    step();
    chk("R2 enabled requests", int'(xoff_valid), 1);

    // R3: global enable
    clear_all();
    fc_tx_en = 1'b0;
    hi_cfg[1] = mk_cfg(1'b1, 4);
    fill_level[1] = FW'(100);
    repeat (4) step();
    chk("R3 gated off", int'(xoff_valid), 0);
    fc_tx_en = 1'b1;
    step();
    chk("R3 request after enable", int'(xoff_valid), 1);
    chk("R3 index", int'(xoff_idx), 1);

    // R4: edge detection and re-arm
    clear_all();
    hi_cfg = '0; refresh_thr = '0;
    hi_cfg[0] = mk_cfg(1'b1, 4);
    fill_level[0] = FW'(80);
    step(); xfer();
    repeat (20) step();
    chk("R4 no repeat while high", int'(xoff_valid), 0);
    fill_level[0] = FW'(40);
    step();
    chk("R4 no request between marks", int'(xoff_valid), 0);
    fill_level[0] = FW'(5);
    step();
    fill_level[0] = FW'(80);
    step();
    chk("R4 re-armed request", int'(xoff_valid), 1);

    // R5: priority and back-to-back
    clear_all();
    hi_cfg = '0;
    for (int k = 1; k < NB; k++) begin
      hi_cfg[k] = mk_cfg(1'b1, 4); fill_level[k] = FW'(100);
    end
    step();
    chk("R5 first index", int'(xoff_idx), 1);
    xfer();
    chk("R5 back-to-back valid", int'(xoff_valid), 1);
    chk("R5 second index", int'(xoff_idx), 2);
    xfer();
    chk("R5 third index", int'(xoff_idx), 3);
    xfer();
    chk("R5 queue empty", int'(xoff_valid), 0);

    // R6: hold under back-pressure
    clear_all();
    hi_cfg = '0;
    hi_cfg[2] = mk_cfg(1'b1, 4); hi_cfg[1] = mk_cfg(1'b1, 4);
    fill_level[2] = FW'(90);
    step();
    for (int c = 0; c < 6; c++) begin
      if (c == 2) fill_level[1] = FW'(90);
      step();
      chk("R6 valid held", int'(xoff_valid), 1);
      chk("R6 index stable", int'(xoff_idx), 2);
    end
    xfer();
    chk("R6 queued lower index", int'(xoff_idx), 1);

    // R7: paused state
    clear_all();
    hi_cfg = '0;
    hi_cfg[0] = mk_cfg(1'b1, 4); hi_cfg[1] = mk_cfg(1'b1, 4);
    hi_cfg[2] = mk_cfg(1'b0, 4);
    for (int k = 0; k < NB; k++) lo_thr[k] = 15'd2;
    fill_level[2] = FW'(200);
    fill_level[0] = FW'(80);
    step();
    chk("R7 not paused before transfer", int'(paused), 0);
    xfer();
    chk("R7 paused after transfer", int'(paused), 1);
    fill_level[0] = FW'(10); fill_level[1] = FW'(40);
    step();
    chk("R7 held by congested buffer", int'(paused), 1);
    fill_level[1] = FW'(10);
    step();
    chk("R7 cleared", int'(paused), 0);
    for (int k = 0; k < NB; k++) lo_thr[k] = 15'd1;

    // R8: refresh interval sweep
    for (int t = 1; t < (1 << RW); t++) begin
      clear_all();
      hi_cfg = '0; refresh_thr = RW'(t); tick_en = 1'b1;
      hi_cfg[0] = mk_cfg(1'b1, 4);
      fill_level[0] = FW'(80);
      step(); xfer();
      wait_req(n);
      chk("R8 refresh interval", n, t);
      refresh_thr = '0;
    end

    // R8: refresh index is lowest congested buffer
    clear_all();
    hi_cfg = '0;
    hi_cfg[1] = mk_cfg(1'b1, 4); hi_cfg[3] = mk_cfg(1'b1, 4);
    fill_level[3] = FW'(80);
    step();
    fill_level[1] = FW'(40);
    refresh_thr = RW'(3);
    xfer();
    wait_req(n);
    chk("R8 refresh after 3", n, 3);
    chk("R8 refresh index", int'(xoff_idx), 1);
    refresh_thr = '0;

    // R9: tick enable freezes the count
    clear_all();
    hi_cfg = '0;
    hi_cfg[0] = mk_cfg(1'b1, 4);
    refresh_thr = RW'(3); tick_en = 1'b0;
    fill_level[0] = FW'(80);
    step(); xfer();
    repeat (20) step();
    chk("R9 frozen without tick", int'(xoff_valid), 0);
    tick_en = 1'b1;
    wait_req(n);
    chk("R9 resumes on tick", n, 3);
    refresh_thr = '0;
    clear_all();

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule